// File: doc/BRIEF.md
# Software Write-Protect Command Sequencer

This block sits in front of a page-programmed non-volatile array and decides, load by load, whether a captured write may be committed to the array. It watches the chip-select, write-enable and output-enable strobes. It captures each qualified write load as an address and a data word, and classifies that load as a command, a permitted write or a rejected write.

A persistent protect flag governs the classification. While the flag is clear, ordinary writes go through. While it is set, a write page is committed only when it opens with a three-load unlock prefix. A longer six-load sequence clears the flag. The unlock prefix used on an unprotected part sets the flag at the close of that page. Command loads are reported as such so that the array controller never stores them.

A page stays open while loads keep arriving. It closes after a quiet window, and a pending change to the flag takes effect at that moment. Hardware inhibits suppress loads: a low supply-good input, a hold-off period after the supply recovers, and strobes that are too short. The flag survives supply loss and is cleared only by the reset input.

Top module: `swp_sequencer`

## Requirements
- R1: A load is a strobe with cs_n=0, we_n=0 and oe_n=1 held for at least GLITCH_CYC consecutive clock cycles. It raises load_stb for one cycle, in the cycle after the strobe ends. load_addr holds the address from the strobe's first cycle and load_data holds the data from its last cycle. A shorter strobe, or one made with oe_n=0, produces no load.
- R2: While pwr_ok is 0, and for HOLD_CYC cycles after it returns to 1, strobes produce no load.
- R3: With protected_o=0, an ordinary load gives load_permit=1 and load_cmd=0.
- R4: The unlock prefix compares address bits [14:0] and requires every byte lane of the data to carry the same byte. Its loads are byte AA to address 5555, then 55 to 2AAA, then A0 to 5555. Each of these loads reports load_cmd=1 and load_permit=0. Later loads in the same page report load_permit=1.
- R5: A page closes when WIN_CYC cycles pass without a load. After the unlock prefix, protected_o becomes 1 at page close, even when no data load followed. It does not change before then.
- R6: With protected_o=1, a load not preceded in its page by the unlock prefix reports load_permit=0 and load_cmd=0.
- R7: With protected_o=1, the unlock prefix permits the loads after it in the same page, and protected_o stays 1.
- R8: The disable sequence is AA to 5555, 55 to 2AAA, 80 to 5555, AA to 5555, 55 to 2AAA, 20 to 5555. All six loads report load_cmd=1. Loads after them in the same page are permitted. protected_o becomes 0 at page close.
- R9: A load that does not match the next expected step of a partial sequence resets the tracker and is classified as an ordinary load. A following load that matches a middle step (55 to 2AAA) is also classified as an ordinary load, not a command.
- R10: A drop of pwr_ok leaves protected_o unchanged and abandons the open page, so a pending change to the flag is not applied. Only rst_n clears protected_o. After reset, protected_o=0 and load_stb=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the only clear of the protect flag |
| pwr_ok | input | 1 | Supply-good indication; 0 inhibits writes |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; must be high for a write |
| addr | input | ADDR_W | Write address |
| wdata | input | DATA_W | Write data |
| load_stb | output | 1 | One-cycle pulse marking a captured load |
| load_addr | output | ADDR_W | Address of the captured load |
| load_data | output | DATA_W | Data of the captured load |
| load_permit | output | 1 | Load may be programmed into the array |
| load_cmd | output | 1 | Load is a command step and must not be stored |
| protected_o | output | 1 | Current protect flag |

## Verification
The bench builds the block with a 16-bit data word, so the byte-lane replication of command data is exercised across two lanes. It sets a 3-cycle strobe filter, so both the just-too-short and the minimum accepted strobe can be driven. A 20-cycle hold-off and a 16-cycle page window keep power recovery and page close within a few dozen cycles. That makes it cheap to probe protected_o just before and just after page close, and to drop the supply in the middle of an open page.

// File: rtl/swp_pkg.sv
`timescale 1ns/1ps
package swp_pkg;
   localparam int unsigned CMD_AW = 15;

   localparam logic [CMD_AW-1:0] ADR_HI = 15'h5555;
   localparam logic [CMD_AW-1:0] ADR_LO = 15'h2AAA;

   localparam logic [7:0] BYT_AA  = 8'hAA;
   localparam logic [7:0] BYT_55  = 8'h55;
   localparam logic [7:0] BYT_EN  = 8'hA0;
   localparam logic [7:0] BYT_D80 = 8'h80;
   localparam logic [7:0] BYT_D20 = 8'h20;

   typedef enum logic [2:0] {
      K0 = 3'd0,
      K1 = 3'd1,
      K2 = 3'd2,
      K3 = 3'd3,
      K4 = 3'd4,
      K5 = 3'd5
   } seq_step_e;
endpackage

// File: rtl/swp_holdoff.sv
`timescale 1ns/1ps
module swp_holdoff #(
   parameter int unsigned HOLD_CYC = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_ok,
   output logic ready
);
   localparam int unsigned HW = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1);

   logic [HW-1:0] hcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt_q <= HW'(HOLD_CYC);
      end else if (!pwr_ok) begin
         hcnt_q <= HW'(HOLD_CYC);
      end else if (hcnt_q != '0) begin
         hcnt_q <= hcnt_q - 1'b1;
      end
   end

   assign ready = pwr_ok && (hcnt_q == '0);
endmodule

// File: rtl/swp_strobe_filter.sv
`timescale 1ns/1ps
module swp_strobe_filter #(
   parameter int unsigned ADDR_W     = 15,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned GLITCH_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ready,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              cap_stb,
   output logic [ADDR_W-1:0] cap_addr,
   output logic [DATA_W-1:0] cap_data
);
   localparam int unsigned GW = $clog2(GLITCH_CYC + 1);

   logic          act;
   logic          act_q;
   logic [GW-1:0] wcnt_q;

   assign act = !cs_n && !we_n && oe_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= 1'b0;
         wcnt_q   <= '0;
         cap_stb  <= 1'b0;
         cap_addr <= '0;
         cap_data <= '0;
      end else begin
         cap_stb <= 1'b0;
         if (act) begin
            act_q    <= 1'b1;
            cap_data <= wdata;
            if (!act_q) begin
               cap_addr <= addr;
               wcnt_q   <= GW'(1);
            end else if (wcnt_q < GW'(GLITCH_CYC)) begin
               wcnt_q <= wcnt_q + 1'b1;
            end
         end else if (act_q) begin
            act_q   <= 1'b0;
            cap_stb <= ready && (wcnt_q >= GW'(GLITCH_CYC));
         end
      end
   end
endmodule

// File: rtl/swp_cmd_tracker.sv
`timescale 1ns/1ps
module swp_cmd_tracker
   import swp_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              stb,
   input  logic              bypass,
   input  logic [CMD_AW-1:0] addr15,
   input  logic [DATA_W-1:0] data,
   output logic              hit,
   output logic              done_en,
   output logic              done_dis
);
   localparam int unsigned LANES = DATA_W / 8;

   seq_step_e         step_q;
   logic [LANES-1:0]  lane_eq;
   logic              all_eq;
   logic [7:0]        byt;
   logic [CMD_AW-1:0] exp_adr;
   logic [7:0]        exp_byt;
   logic              alt_ok;

   assign byt = data[7:0];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_eq[i] = (data[8*i +: 8] == byt);
   end
   assign all_eq = &lane_eq;

   always_comb begin
      exp_adr = ADR_HI;
      exp_byt = BYT_AA;
      alt_ok  = 1'b0;
      unique case (step_q)
         K0: ;
         K1: begin exp_adr = ADR_LO; exp_byt = BYT_55; end
         K2: begin exp_byt = BYT_EN; alt_ok = 1'b1; end
         K3: ;
         K4: begin exp_adr = ADR_LO; exp_byt = BYT_55; end
         K5: exp_byt = BYT_D20;
         default: ;
      endcase
   end

   assign hit = stb && !bypass && all_eq && (addr15 == exp_adr) &&
                ((byt == exp_byt) || (alt_ok && (byt == BYT_D80)));
   assign done_en  = hit && (step_q == K2) && (byt == BYT_EN);
   assign done_dis = hit && (step_q == K5);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= K0;
      end else if (clr) begin
         step_q <= K0;
      end else if (stb) begin
         if (!hit || done_en || done_dis) begin
            step_q <= K0;
         end else if (step_q == K2) begin
            step_q <= K3;
         end else begin
            step_q <= seq_step_e'(step_q + 3'd1);
         end
      end
   end
endmodule

// File: rtl/swp_sequencer.sv
`timescale 1ns/1ps
module swp_sequencer
   import swp_pkg::*;
#(
   parameter int unsigned ADDR_W     = 15,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned GLITCH_CYC = 3,
   parameter int unsigned HOLD_CYC   = 1000000,
   parameter int unsigned WIN_CYC    = 30000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_ok,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              load_stb,
   output logic [ADDR_W-1:0] load_addr,
   output logic [DATA_W-1:0] load_data,
   output logic              load_permit,
   output logic              load_cmd,
   output logic              protected_o
);
   localparam int unsigned WW = $clog2(WIN_CYC + 1);

   if (ADDR_W < CMD_AW) begin : g_bad_aw
      $error("swp_sequencer: ADDR_W must be at least 15");
   end
   if ((DATA_W == 0) || (DATA_W % 8 != 0)) begin : g_bad_dw
      $error("swp_sequencer: DATA_W must be a non-zero multiple of 8");
   end
   if (GLITCH_CYC < 1) begin : g_bad_gl
      $error("swp_sequencer: GLITCH_CYC must be at least 1");
   end
   if (WIN_CYC < 2) begin : g_bad_win
      $error("swp_sequencer: WIN_CYC must be at least 2");
   end

   logic          ready;
   logic          cap_stb;
   logic          hit;
   logic          done_en;
   logic          done_dis;
   logic          page_end;
   logic          trk_clr;
   logic          prot_q;
   logic          unl_q;
   logic          arm_set_q;
   logic          arm_clr_q;
   logic          page_q;
   logic [WW-1:0] win_q;

   swp_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .pwr_ok (pwr_ok),
      .ready  (ready)
   );

   swp_strobe_filter #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .GLITCH_CYC (GLITCH_CYC)
   ) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .ready    (ready),
      .cs_n     (cs_n),
      .we_n     (we_n),
      .oe_n     (oe_n),
      .addr     (addr),
      .wdata    (wdata),
      .cap_stb  (cap_stb),
      .cap_addr (load_addr),
      .cap_data (load_data)
   );

   assign page_end = pwr_ok && !cap_stb && page_q && (win_q == WW'(1));
   assign trk_clr  = page_end || !pwr_ok;

   swp_cmd_tracker #(.DATA_W(DATA_W)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (trk_clr),
      .stb      (cap_stb),
      .bypass   (unl_q),
      .addr15   (load_addr[CMD_AW-1:0]),
      .data     (load_data),
      .hit      (hit),
      .done_en  (done_en),
      .done_dis (done_dis)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_q    <= 1'b0;
         unl_q     <= 1'b0;
         arm_set_q <= 1'b0;
         arm_clr_q <= 1'b0;
         page_q    <= 1'b0;
         win_q     <= '0;
      end else if (!pwr_ok) begin
         unl_q     <= 1'b0;
         arm_set_q <= 1'b0;
         arm_clr_q <= 1'b0;
         page_q    <= 1'b0;
         win_q     <= '0;
      end else if (cap_stb) begin
         page_q <= 1'b1;
         win_q  <= WW'(WIN_CYC);
         if (done_en) begin
            unl_q     <= 1'b1;
            arm_set_q <= 1'b1;
            arm_clr_q <= 1'b0;
         end else if (done_dis) begin
            unl_q     <= 1'b1;
            arm_set_q <= 1'b0;
            arm_clr_q <= 1'b1;
         end
      end else if (page_q) begin
         if (page_end) begin
            page_q    <= 1'b0;
            unl_q     <= 1'b0;
            arm_set_q <= 1'b0;
            arm_clr_q <= 1'b0;
            if (arm_set_q) begin
               prot_q <= 1'b1;
            end else if (arm_clr_q) begin
               prot_q <= 1'b0;
            end
         end else begin
            win_q <= win_q - 1'b1;
         end
      end
   end

   assign load_stb    = cap_stb;
   assign load_cmd    = hit;
   assign load_permit = cap_stb && !hit && (unl_q || !prot_q);
   assign protected_o = prot_q;
endmodule

// File: rtl/swp_sequencer_chk.sv
`timescale 1ns/1ps
module swp_sequencer_chk #(
   parameter int unsigned GLITCH_CYC = 3
) (
   input logic clk,
   input logic rst_n,
   input logic pwr_ok,
   input logic cs_n,
   input logic we_n,
   input logic oe_n,
   input logic load_stb,
   input logic protected_o
);
   localparam int unsigned GW = $clog2(GLITCH_CYC + 1);

   logic          act;
   logic          act_d;
   logic [GW-1:0] cnt_q;

   assign act = !cs_n && !we_n && oe_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_d <= 1'b0;
         cnt_q <= '0;
      end else begin
         act_d <= act;
         if (!act) begin
            cnt_q <= '0;
         end else if (cnt_q < GW'(GLITCH_CYC)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R1: a strobe that ended before reaching the filter width yields no load
   p_short_strobe_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (act_d && !act && (cnt_q < GW'(GLITCH_CYC))) |=> !load_stb);

   // R2: no load follows a cycle with the supply low
   p_no_load_unpowered_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_ok |=> !load_stb);

   // R5: the protect flag moves only at a quiet page close
   p_prot_moves_at_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(protected_o) |-> !$past(load_stb));

   // R10: a supply drop leaves the protect flag alone
   p_prot_kept_on_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_ok) |=> $stable(protected_o));
endmodule

bind swp_sequencer swp_sequencer_chk #(.GLITCH_CYC(GLITCH_CYC)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pwr_ok      (pwr_ok),
   .cs_n        (cs_n),
   .we_n        (we_n),
   .oe_n        (oe_n),
   .load_stb    (load_stb),
   .protected_o (protected_o)
);

// File: tb/swp_sequencer_tb_top.sv
`timescale 1ns/1ps
module swp_sequencer_tb_top;
   localparam int unsigned AW   = 15;
   localparam int unsigned DW   = 16;
   localparam int unsigned GL   = 3;
   localparam int unsigned HOLD = 20;
   localparam int unsigned WIN  = 16;

   typedef struct packed {
      logic [14:0] a;
      logic [15:0] d;
      logic        cmd;
      logic        perm;
      logic        close;
      logic        prot;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VEC [0:NV-1] = '{
      '{15'h0100, 16'h1234, 1'b0, 1'b1, 1'b1, 1'b0},
      '{15'h5555, 16'hAAAA, 1'b1, 1'b0, 1'b0, 1'b0},
      '{15'h2AAA, 16'h5555, 1'b1, 1'b0, 1'b0, 1'b0},
      '{15'h5555, 16'hA0A0, 1'b1, 1'b0, 1'b0, 1'b0},
      '{15'h0040, 16'hBEEF, 1'b0, 1'b1, 1'b1, 1'b1},
      '{15'h0200, 16'h1111, 1'b0, 1'b0, 1'b1, 1'b1},
      '{15'h5555, 16'hAAAA, 1'b1, 1'b0, 1'b0, 1'b1},
      '{15'h2AAA, 16'h5555, 1'b1, 1'b0, 1'b0, 1'b1},
      '{15'h5555, 16'hA0A0, 1'b1, 1'b0, 1'b0, 1'b1},
      '{15'h0300, 16'h2222, 1'b0, 1'b1, 1'b1, 1'b1},
      '{15'h5555, 16'hAAAA, 1'b1, 1'b0, 1'b0, 1'b1},
      '{15'h2AAA, 16'h5555, 1'b1, 1'b0, 1'b0, 1'b1},
      '{15'h0400, 16'h7777, 1'b0, 1'b0, 1'b0, 1'b1},
      '{15'h2AAA, 16'h5555, 1'b0, 1'b0, 1'b1, 1'b1},
      '{15'h5555, 16'hAAAA, 1'b1, 1'b0, 1'b0, 1'b1},
      '{15'h2AAA, 16'h5555, 1'b1, 1'b0, 1'b0, 1'b1},
      '{15'h5555, 16'h8080, 1'b1, 1'b0, 1'b0, 1'b1},
      '{15'h5555, 16'hAAAA, 1'b1, 1'b0, 1'b0, 1'b1},
      '{15'h2AAA, 16'h5555, 1'b1, 1'b0, 1'b0, 1'b1},
      '{15'h5555, 16'h2020, 1'b1, 1'b0, 1'b0, 1'b1},
      '{15'h0500, 16'h3333, 1'b0, 1'b1, 1'b1, 1'b0},
      '{15'h0600, 16'h4444, 1'b0, 1'b1, 1'b1, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pwr_ok = 1'b1;
   logic          cs_n = 1'b1;
   logic          we_n = 1'b1;
   logic          oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          load_stb;
   logic [AW-1:0] load_addr;
   logic [DW-1:0] load_data;
   logic          load_permit;
   logic          load_cmd;
   logic          protected_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic          seen;
   logic [AW-1:0] got_a;
   logic [DW-1:0] got_d;
   logic          got_perm;
   logic          got_cmd;

   always #2.5 clk = ~clk;

   swp_sequencer #(
      .ADDR_W(AW), .DATA_W(DW), .GLITCH_CYC(GL), .HOLD_CYC(HOLD), .WIN_CYC(WIN)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .cs_n(cs_n), .we_n(we_n),
      .oe_n(oe_n), .addr(addr), .wdata(wdata), .load_stb(load_stb),
      .load_addr(load_addr), .load_data(load_data), .load_permit(load_permit),
      .load_cmd(load_cmd), .protected_o(protected_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic strobe(input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                         input logic [AW-1:0] a2, input logic [DW-1:0] d2,
                         input int n, input logic oe);
      @(negedge clk);
      addr = a1; wdata = d1; cs_n = 1'b0; we_n = 1'b0; oe_n = oe;
      for (int k = 1; k < n; k++) begin
         @(negedge clk);
         addr = a2; wdata = d2;
      end
      @(negedge clk);
      cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      seen = 1'b0; got_a = '0; got_d = '0; got_perm = 1'b0; got_cmd = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         if (load_stb) begin
            seen = 1'b1; got_a = load_addr; got_d = load_data;
            got_perm = load_permit; got_cmd = load_cmd;
         end
      end
   endtask

   task automatic load(input logic [AW-1:0] a, input logic [DW-1:0] d);
      strobe(a, d, a, d, GL + 1, 1'b1);
   endtask

   task automatic finish_run;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(protected_o == 1'b0, "R10", "reset protect", protected_o, 0);
      check(load_stb == 1'b0, "R10", "reset load_stb", load_stb, 0);

      // R2: hold-off after reset suppresses a valid strobe
      load(15'h0010, 16'h0101);
      check(seen == 1'b0, "R2", "load during hold-off", seen, 0);
      repeat (HOLD + 2) @(negedge clk);

      // R1: short strobe, oe low strobe, capture points
      strobe(15'h0011, 16'h0202, 15'h0011, 16'h0202, GL - 1, 1'b1);
      check(seen == 1'b0, "R1", "short strobe load", seen, 0);
      strobe(15'h0012, 16'h0303, 15'h0012, 16'h0303, GL + 2, 1'b0);
      check(seen == 1'b0, "R1", "oe low strobe load", seen, 0);
      strobe(15'h0013, 16'h0404, 15'h0077, 16'h0505, GL, 1'b1);
      check(seen == 1'b1, "R1", "minimum strobe load", seen, 1);
      check(got_a == 15'h0013, "R1", "address from first cycle", got_a, 32'h13);
      check(got_d == 16'h0505, "R1", "data from last cycle", got_d, 32'h505);
      repeat (WIN + 4) @(negedge clk);

      // Vector walk: R3 R4 R5 R6 R7 R8 R9
      for (int i = 0; i < NV; i++) begin
         load(VEC[i].a, VEC[i].d);
         check(seen == 1'b1, "R3/R4/R6/R7/R8/R9", $sformatf("vec %0d seen", i), seen, 1);
         check(got_cmd == VEC[i].cmd, "R4/R8/R9", $sformatf("vec %0d cmd", i),
               got_cmd, VEC[i].cmd);
         check(got_perm == VEC[i].perm, "R3/R6/R7/R9", $sformatf("vec %0d permit", i),
               got_perm, VEC[i].perm);
         if (VEC[i].close) begin
            repeat (WIN + 4) @(negedge clk);
            check(protected_o == VEC[i].prot, "R5/R7/R8", $sformatf("vec %0d protect", i),
                  protected_o, VEC[i].prot);
         end
      end

      // R5: prefix alone sets protection only at page close
      load(15'h5555, 16'hAAAA);
      load(15'h2AAA, 16'h5555);
      load(15'h5555, 16'hA0A0);
      repeat (WIN / 2) @(negedge clk);
      check(protected_o == 1'b0, "R5", "protect before close", protected_o, 0);
      repeat (WIN + 4) @(negedge clk);
      check(protected_o == 1'b1, "R5", "protect after close", protected_o, 1);

      // R10 and R2: supply drop keeps the flag; loads suppressed
      @(negedge clk);
      pwr_ok = 1'b0;
      repeat (3) @(negedge clk);
      check(protected_o == 1'b1, "R10", "protect after drop", protected_o, 1);
      load(15'h0700, 16'h5A5A);
      check(seen == 1'b0, "R2", "load with supply low", seen, 0);
      pwr_ok = 1'b1;
      load(15'h0701, 16'h5A5A);
      check(seen == 1'b0, "R2", "load just after supply up", seen, 0);
      repeat (HOLD + 2) @(negedge clk);
      load(15'h0702, 16'h6B6B);
      check(seen == 1'b1 && got_perm == 1'b0, "R6", "protected load after recovery",
            {seen, got_perm}, 32'h2);
      repeat (WIN + 4) @(negedge clk);

      // R10: disable sequence abandoned by supply drop
      load(15'h5555, 16'hAAAA);
      load(15'h2AAA, 16'h5555);
      load(15'h5555, 16'h8080);
      load(15'h5555, 16'hAAAA);
      load(15'h2AAA, 16'h5555);
      load(15'h5555, 16'h2020);
      check(got_cmd == 1'b1, "R8", "last disable step cmd", got_cmd, 1);
      pwr_ok = 1'b0;
      repeat (3) @(negedge clk);
      pwr_ok = 1'b1;
      repeat (HOLD + WIN + 4) @(negedge clk);
      check(protected_o == 1'b1, "R10", "abandoned disable", protected_o, 1);

      // R10: only reset clears the flag
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(protected_o == 1'b0, "R10", "protect after reset", protected_o, 0);
      check(load_stb == 1'b0, "R10", "load_stb after reset", load_stb, 0);

      finish_run();
   end
endmodule